// File: doc/BRIEF.md
# Wide Register with Shadowed Writes and Snapshot Reads

This block holds one control/status register that is wider than the CPU data path, for example 64 bits reached through 32-bit transfers. The register is divided into access-width sub-words. Each sub-word is selected by a small index on the bus port. Without help, software that updates or samples such a register one sub-word at a time can see a torn value. The block offers two independent remedies, each chosen by a parameter.

Write shadowing sends every sub-word write into a staging copy. The live register output changes only when a commit happens, and then all bits change together. By default the commit comes from a write to the highest sub-word. A parameter can instead give that job to a one-bit pulse input. Read snapshots work in a similar way. The hardware value is frozen into a holding copy when a capture happens, and later sub-word reads return that frozen copy. By default the capture comes from a read of sub-word zero. A parameter can instead give that job to a one-bit pulse input. When a remedy is switched off, its path becomes a plain direct access. Because the register moves as a whole, fields that cross a sub-word boundary are safe only when shadowing is in use.

Top module: `wide_csr_dbuf`

## Requirements
- R1: On reset, the live register output, the write shadow and the read snapshot all take the parameter RESET_VAL, and the read data output is zero.
- R2: With write shadowing and the internal commit, a write to sub-word index NSUB-1 (the highest) copies the whole shadow, including that write, to the register output on the same clock edge. Writes to lower indices leave the output unchanged.
- R3: Strobe bit b replaces byte b (bits 8b+7..8b) of the addressed sub-word, where sub-word i occupies bits i*ACC_W upward. Bytes that are not strobed keep their value. The shadow keeps its contents after a commit, so a top-word write with all strobes low commits the shadow unchanged.
- R4: With write shadowing and the external commit, no write at any index changes the register output. A one-cycle high on the write trigger input copies the shadow to the output.
- R5: When a commit and a sub-word write fall on the same edge, the committed value contains that write.
- R6: With read snapshots and the internal capture, a read of index 0 returns bits ACC_W-1..0 of the hardware input and freezes the full hardware input in the snapshot. Reads of other indices return the snapshot.
- R7: With read snapshots and the external capture, a one-cycle high on the read trigger input freezes the hardware input. Reads of every index, including 0, return the snapshot.
- R8: With both remedies disabled, a write updates the strobed bytes of the register output directly on its edge, and a read returns the addressed sub-word of the current hardware input.
- R9: Read data is registered. It changes on the edge that takes a read request and holds its value through idle and write cycles.
- R10: An index of NSUB or above changes no state on a write and returns zero on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Bus transfer valid this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuIdx | input | IDX_W | Sub-word index |
| cpuWdata | input | ACC_W | Write data |
| cpuStrb | input | ACC_W/8 | Byte write strobes |
| cpuRdata | output | ACC_W | Registered read data |
| hwValue | input | REG_W | Hardware-side value that is read back |
| wTrig | input | 1 | External commit pulse (used when WTRIG_EXT=1) |
| rTrig | input | 1 | External capture pulse (used when RTRIG_EXT=1) |
| regOut | output | REG_W | Live register value |

## Verification
A shadow byte that was corrupted stays hidden until the next commit. It then shows up in every bit of the register output on the same edge. The bench therefore commits after each sweep and compares the whole output. A snapshot that was frozen at the wrong moment shows up on the first read of a non-zero index, one cycle after the request. For this reason the hardware input is changed between the capture and those reads. A commit or capture at the wrong time shows up at once as an output step where none should occur.

// File: rtl/csr_dbuf_pkg.sv
package csr_dbuf_pkg;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic bufWr;    // merge write data into the shadow
    logic liveWr;   // merge write data straight into the live register
    logic commit;   // copy shadow (plus same-cycle write) to live
    logic snapCap;  // freeze the hardware value
    logic rdEn;     // load read data this cycle
    logic rdLive;   // read from hardware value instead of snapshot
    logic idxOk;    // index within range
  } csrStrobes_t;

endpackage

// File: rtl/csr_dbuf_ctrl.sv
module csr_dbuf_ctrl
  import csr_dbuf_pkg::*;
#(
  parameter int NSUB      = 2,
  parameter int IDX_W     = 1,
  parameter bit WBUF_EN   = 1'b1,
  parameter bit RBUF_EN   = 1'b1,
  parameter bit WTRIG_EXT = 1'b0,
  parameter bit RTRIG_EXT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic              wTrig,
  input  logic              rTrig,
  output csrStrobes_t       stb
);

  localparam logic [IDX_W:0]   SUB_CNT = (IDX_W+1)'(NSUB);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSUB - 1);

  logic idxOk, wrHit, rdHit, isTop, isBottom;

  assign idxOk    = {1'b0, cpuIdx} < SUB_CNT;
  assign wrHit    = cpuReq && cpuWrite && idxOk;
  assign rdHit    = cpuReq && !cpuWrite;
  assign isTop    = cpuIdx == TOP_IDX;
  assign isBottom = cpuIdx == '0;

  always_comb begin
    stb         = '0;
    stb.idxOk   = idxOk;
    stb.bufWr   = WBUF_EN && wrHit;
    stb.liveWr  = !WBUF_EN && wrHit;
    stb.commit  = WBUF_EN && (WTRIG_EXT ? wTrig : (wrHit && isTop));
    stb.snapCap = RBUF_EN && (RTRIG_EXT ? rTrig : (rdHit && isBottom));
    stb.rdEn    = rdHit;
    stb.rdLive  = !RBUF_EN || (!RTRIG_EXT && isBottom);
  end

  // R10
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWrite && ({1'b0, cpuIdx} >= SUB_CNT)) |-> !(stb.bufWr || stb.liveWr));

  // R8
  wr_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bufWr, stb.liveWr}));

  generate
    if (WBUF_EN && !WTRIG_EXT) begin : gIntCommitChk
      // R2
      int_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.commit |-> (cpuReq && cpuWrite && isTop));
    end
    if (RBUF_EN && RTRIG_EXT) begin : gExtSnapChk
      // R7
      ext_read_src_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.rdEn |-> !stb.rdLive);
    end
  endgenerate

endmodule

// File: rtl/csr_dbuf_dpath.sv
module csr_dbuf_dpath
  import csr_dbuf_pkg::*;
#(
  parameter int               REG_W     = 64,
  parameter int               ACC_W     = 32,
  parameter int               NSUB      = 2,
  parameter int               IDX_W     = 1,
  parameter int               STRB_W    = 4,
  parameter bit               WBUF_EN   = 1'b1,
  parameter bit               RBUF_EN   = 1'b1,
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobes_t        stb,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic [ACC_W-1:0]   cpuWdata,
  input  logic [STRB_W-1:0]  cpuStrb,
  input  logic [REG_W-1:0]   hwValue,
  output logic [ACC_W-1:0]   cpuRdata,
  output logic [REG_W-1:0]   regOut
);

  logic [REG_W-1:0] liveQ, bufQ, snapQ, wrMerged, rdSrc;
  logic [IDX_W-1:0] idxC;

  function automatic logic [REG_W-1:0] mergeSub(
    input logic [REG_W-1:0]  base,
    input logic [IDX_W-1:0]  idx,
    input logic [ACC_W-1:0]  data,
    input logic [STRB_W-1:0] strb
  );
    logic [REG_W-1:0] res;
    res = base;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) res[int'(idx)*ACC_W + b*8 +: 8] = data[b*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [ACC_W-1:0] pickSub(
    input logic [REG_W-1:0] v,
    input logic [IDX_W-1:0] idx
  );
    return v[int'(idx)*ACC_W +: ACC_W];
  endfunction

  // Out-of-range indices are clipped; strobes already block their effect
  assign idxC     = stb.idxOk ? cpuIdx : '0;
  assign wrMerged = mergeSub(bufQ, idxC, cpuWdata, cpuStrb);

  // Live register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               liveQ <= RESET_VAL;
    else if (stb.commit)     liveQ <= stb.bufWr ? wrMerged : bufQ;
    else if (stb.liveWr)     liveQ <= wrMerged;
  end
  assign regOut = liveQ;

  generate
    if (WBUF_EN) begin : gShadow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          bufQ <= RESET_VAL;
        else if (stb.bufWr) bufQ <= wrMerged;
      end
      // R5
      commit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.commit |=> (liveQ == bufQ));
    end else begin : gNoShadow
      assign bufQ = liveQ;
    end

    if (RBUF_EN) begin : gSnap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            snapQ <= RESET_VAL;
        else if (stb.snapCap) snapQ <= hwValue;
      end
      // R6
      snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !stb.snapCap |=> $stable(snapQ));
      // R7
      snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.snapCap |=> (snapQ == $past(hwValue)));
    end else begin : gNoSnap
      assign snapQ = hwValue;
    end
  endgenerate

  assign rdSrc = stb.rdLive ? hwValue : snapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cpuRdata <= '0;
    else if (stb.rdEn) cpuRdata <= stb.idxOk ? pickSub(rdSrc, idxC) : '0;
  end

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit || stb.liveWr) |=> $stable(liveQ));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(cpuRdata));

endmodule

// File: rtl/wide_csr_dbuf.sv
module wide_csr_dbuf
  import csr_dbuf_pkg::*;
#(
  parameter int               REG_W     = 64,
  parameter int               ACC_W     = 32,
  parameter bit               WBUF_EN   = 1'b1,
  parameter bit               RBUF_EN   = 1'b1,
  parameter bit               WTRIG_EXT = 1'b0,
  parameter bit               RTRIG_EXT = 1'b0,
  parameter logic [REG_W-1:0] RESET_VAL = '0,
  localparam int              NSUB      = REG_W / ACC_W,
  localparam int              IDX_W     = (NSUB > 1) ? $clog2(NSUB) : 1,
  localparam int              STRB_W    = ACC_W / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuWrite,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic [ACC_W-1:0]   cpuWdata,
  input  logic [STRB_W-1:0]  cpuStrb,
  output logic [ACC_W-1:0]   cpuRdata,
  input  logic [REG_W-1:0]   hwValue,
  input  logic               wTrig,
  input  logic               rTrig,
  output logic [REG_W-1:0]   regOut
);

  csrStrobes_t stb;

  csr_dbuf_ctrl #(
    .NSUB(NSUB), .IDX_W(IDX_W), .WBUF_EN(WBUF_EN), .RBUF_EN(RBUF_EN),
    .WTRIG_EXT(WTRIG_EXT), .RTRIG_EXT(RTRIG_EXT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuIdx(cpuIdx), .wTrig(wTrig), .rTrig(rTrig), .stb(stb)
  );

  csr_dbuf_dpath #(
    .REG_W(REG_W), .ACC_W(ACC_W), .NSUB(NSUB), .IDX_W(IDX_W), .STRB_W(STRB_W),
    .WBUF_EN(WBUF_EN), .RBUF_EN(RBUF_EN), .RESET_VAL(RESET_VAL)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuIdx(cpuIdx), .cpuWdata(cpuWdata),
    .cpuStrb(cpuStrb), .hwValue(hwValue), .cpuRdata(cpuRdata), .regOut(regOut)
  );

endmodule

// File: tb/wide_csr_dbuf_bench.sv
`timescale 1ns/1ps
module wide_csr_dbuf_bench;

  localparam logic [47:0] RST = 48'h9A4C_31E7_5B02;

  // DUT 0: both buffers, internal triggers. DUT 1: external triggers. DUT 2: unbuffered.
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req [3];
  logic        wr  [3];
  logic [1:0]  idx [3];
  logic [15:0] wd  [3];
  logic [1:0]  strb[3];
  logic [47:0] hw  [3];
  logic        wt  [3];
  logic        rt  [3];
  logic [15:0] rd  [3];
  logic [47:0] ro  [3];

  logic [47:0] mLive[3], mBuf[3], mSnap[3];
  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;

  wide_csr_dbuf #(.REG_W(48), .ACC_W(16), .WBUF_EN(1), .RBUF_EN(1),
    .WTRIG_EXT(0), .RTRIG_EXT(0), .RESET_VAL(RST)) u_wide_csr_dbuf (
    .clk(clk), .rstN(rstN), .cpuReq(req[0]), .cpuWrite(wr[0]), .cpuIdx(idx[0]),
    .cpuWdata(wd[0]), .cpuStrb(strb[0]), .cpuRdata(rd[0]), .hwValue(hw[0]),
    .wTrig(wt[0]), .rTrig(rt[0]), .regOut(ro[0]));

  wide_csr_dbuf #(.REG_W(48), .ACC_W(16), .WBUF_EN(1), .RBUF_EN(1),
    .WTRIG_EXT(1), .RTRIG_EXT(1), .RESET_VAL(RST)) u_wide_csr_dbuf_ext (
    .clk(clk), .rstN(rstN), .cpuReq(req[1]), .cpuWrite(wr[1]), .cpuIdx(idx[1]),
    .cpuWdata(wd[1]), .cpuStrb(strb[1]), .cpuRdata(rd[1]), .hwValue(hw[1]),
    .wTrig(wt[1]), .rTrig(rt[1]), .regOut(ro[1]));

  wide_csr_dbuf #(.REG_W(48), .ACC_W(16), .WBUF_EN(0), .RBUF_EN(0),
    .WTRIG_EXT(0), .RTRIG_EXT(0), .RESET_VAL(RST)) u_wide_csr_dbuf_raw (
    .clk(clk), .rstN(rstN), .cpuReq(req[2]), .cpuWrite(wr[2]), .cpuIdx(idx[2]),
    .cpuWdata(wd[2]), .cpuStrb(strb[2]), .cpuRdata(rd[2]), .hwValue(hw[2]),
    .wTrig(wt[2]), .rTrig(rt[2]), .regOut(ro[2]));

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Byte-mask merge of one 16-bit sub-word into a 48-bit value
  function automatic logic [47:0] mMerge(input logic [47:0] base, input int i,
                                         input logic [15:0] data, input logic [1:0] s);
    logic [47:0] mask;
    mask = 48'({s[1] ? 8'hFF : 8'h00, s[0] ? 8'hFF : 8'h00}) << (i * 16);
    return (base & ~mask) | ((48'(data) << (i * 16)) & mask);
  endfunction

  task automatic doWrite(input int d, input int i, input logic [15:0] data,
                         input logic [1:0] s, input logic trig, input string tag);
    logic [47:0] merged;
    logic commit;
    req[d] = 1'b1; wr[d] = 1'b1; idx[d] = 2'(i); wd[d] = data; strb[d] = s; wt[d] = trig;
    if (i < 3) begin
      if (d == 2) mLive[d] = mMerge(mLive[d], i, data, s);
      else        mBuf[d]  = mMerge(mBuf[d], i, data, s);
    end
    merged = mBuf[d];
    commit = (d == 0) ? (i == 2) : (d == 1) ? trig : 1'b0;
    if (commit) mLive[d] = merged;
    @(negedge clk);
    req[d] = 1'b0; wr[d] = 1'b0; wt[d] = 1'b0;
    chk(tag, ro[d], mLive[d]);
  endtask

  task automatic doRead(input int d, input int i, input string tag);
    logic [47:0] src;
    logic [15:0] exp;
    req[d] = 1'b1; wr[d] = 1'b0; idx[d] = 2'(i);
    if (d == 2 || (d == 0 && i == 0)) src = hw[d];
    else src = mSnap[d];
    if (d == 0 && i == 0) mSnap[d] = hw[d];
    exp = (i < 3) ? 16'(src >> (i * 16)) : 16'h0000;
    @(negedge clk);
    req[d] = 1'b0;
    chk(tag, 48'(rd[d]), 48'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic [15:0] keep;
    for (int d = 0; d < 3; d++) begin
      req[d] = 0; wr[d] = 0; idx[d] = 0; wd[d] = 0; strb[d] = 0;
      hw[d] = 48'h0; wt[d] = 0; rt[d] = 0;
      mLive[d] = RST; mBuf[d] = RST; mSnap[d] = RST;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int d = 0; d < 3; d++) begin
      chk("R1 regOut", ro[d], RST);
      chk("R1 rdata", 48'(rd[d]), 48'h0);
    end
    hw[0] = 48'hFFFF_FFFF_FFFF; hw[1] = 48'hFFFF_FFFF_FFFF;
    doRead(0, 1, "R1 snapshot reset");
    doRead(1, 2, "R1 snapshot reset ext");

    // R2 R3 R10 sweep with internal commit
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 4; s++)
        doWrite(0, i, 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(s * 16'h2468), 2'(s), 1'b0, "R2 R3 shadow sweep");
    doWrite(0, 0, 16'h1111, 2'b01, 1'b0, "R3 partial lower");
    doWrite(0, 2, 16'hFFFF, 2'b00, 1'b0, "R3 retained commit");
    doWrite(0, 3, 16'h7777, 2'b11, 1'b0, "R10 bad index write");
    doRead(0, 3, "R10 bad index read");

    // R4 sweep with external commit
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 4; s++)
        doWrite(1, i, 16'h3C96 ^ 16'(i * 16'h0F1E) ^ 16'(s * 16'h5A01), 2'(s), 1'b0, "R4 no commit on write");
    wt[1] = 1'b1; mLive[1] = mBuf[1];
    @(negedge clk); wt[1] = 1'b0;
    chk("R4 trigger commit", ro[1], mLive[1]);
    doWrite(1, 1, 16'hBEEF, 2'b11, 1'b1, "R5 same-cycle write and commit");
    doWrite(1, 2, 16'hCAFE, 2'b10, 1'b1, "R5 same-cycle top partial");

    // R6 internal capture
    hw[0] = 48'h1234_5678_9ABC;
    doRead(0, 1, "R6 prior snapshot");
    doRead(0, 0, "R6 capture read");
    hw[0] = 48'hDEAD_BEEF_0F0F;
    doRead(0, 2, "R6 snapshot high");
    doRead(0, 1, "R6 snapshot mid");
    doRead(0, 0, "R6 recapture");
    doRead(0, 2, "R6 new snapshot high");

    // R7 external capture
    hw[1] = 48'h0A0B_0C0D_0E0F;
    rt[1] = 1'b1; mSnap[1] = hw[1];
    @(negedge clk); rt[1] = 1'b0;
    hw[1] = 48'h5555_6666_7777;
    for (int i = 0; i < 4; i++) doRead(1, i, "R7 snapshot read");

    // R8 direct path sweep
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 4; s++)
        doWrite(2, i, 16'h6B2D ^ 16'(i * 16'h1111) ^ 16'(s * 16'h4321), 2'(s), 1'b0, "R8 direct write");
    for (int k = 0; k < 8; k++) begin
      hw[2] = 48'h0123_4567_89AB ^ 48'(k * 48'h1357_9BDF_2468);
      doRead(2, k % 4, "R8 direct read");
    end

    // R9 read data hold
    hw[2] = 48'hAAAA_BBBB_CCCC;
    doRead(2, 1, "R9 load");
    keep = rd[2];
    hw[2] = 48'h1111_2222_3333;
    @(negedge clk);
    chk("R9 hold idle", 48'(rd[2]), 48'(keep));
    doWrite(2, 0, 16'h9999, 2'b11, 1'b0, "R8 direct write");
    chk("R9 hold on write", 48'(rd[2]), 48'(keep));

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule